// File: doc/BRIEF.md
# Hierarchical Status Interrupt Aggregator

This block gathers the status of several subsystems of a line framer into one master status byte that a host processor reads first, so that it can go on to service only the subsystems that need it. Four subsystems (bit-error tester, HDLC controller, far-end alarm channel and framer core) each report a latched status vector and its enable mask. A subsystem's master bit is high while any of its latched status bits is set and that bit is also enabled. Three single-bit conditions sit beside them: error-counter saturation, transmit-clock loss and receive-clock loss.

From this real-time byte the block keeps a latched copy. A bit of the latched copy is set on each rising edge of its real-time bit, and the host clears it by writing 1 to it. A master enable byte selects which latched bits can drive the interrupt output. The output is registered. A small register port with a 2-bit offset, a write strobe, a read strobe and registered read data gives the host access to the live byte, the latched byte and the enable byte.

Top module: `status_aggregator`

## Requirements
- R1: After reset the latched byte and the enable byte read 0 and `irq` is low.
- R2: Live bit 2 (tester), bit 3 (HDLC), bit 4 (alarm channel) and bit 5 (framer) are each 1 exactly when (status AND enable) of that subsystem is non-zero. Each bit falls back to 0 as soon as either the status bits or the enable bits are cleared.
- R3: Live bit 1 follows `cnt_sat`, bit 6 follows `tx_clk_lost`, bit 7 follows `rx_clk_lost`, and bit 0 is always 0.
- R4: A read strobe at offset 0 returns the live byte as it stood at that clock edge. `host_rdata` is valid after the edge that samples `host_rd` and holds until the next read.
- R5: A latched bit (offset 1) becomes 1 at the clock edge where its live bit is 1 and was 0 at the previous edge. It then stays 1 after the live bit falls.
- R6: Writing offset 1 clears each latched bit whose write-data bit is 1 and leaves the others unchanged. A latched bit that has been cleared is not set again while its live bit stays high.
- R7: `irq` is 1 exactly one cycle after a cycle in which (latched byte AND enable byte) is non-zero.
- R8: When a rising live bit and a clearing write to the same latched bit fall in the same cycle, the latched bit ends up set.
- R9: Offset 2 is the read/write enable byte and its bit 0 always reads 0. Writes to offsets 0 and 3 change nothing, and offset 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tst_stat | input | SUB_W | Bit-error tester latched status |
| tst_en | input | SUB_W | Bit-error tester enable mask |
| hdlc_stat | input | SUB_W | HDLC latched status |
| hdlc_en | input | SUB_W | HDLC enable mask |
| alm_stat | input | SUB_W | Far-end alarm channel latched status |
| alm_en | input | SUB_W | Far-end alarm channel enable mask |
| frm_stat | input | SUB_W | Framer core latched status |
| frm_en | input | SUB_W | Framer core enable mask |
| cnt_sat | input | 1 | Any error counter saturated |
| tx_clk_lost | input | 1 | Transmit clock missing |
| rx_clk_lost | input | 1 | Receive clock missing |
| host_addr | input | 2 | Register offset |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt, active high |

## Verification
The live byte is combinational and is captured in `host_rdata` at the same edge that samples the read strobe. A latched bit is set at the first edge after its live bit rises, and a read of offset 1 one edge later shows it. `irq` follows a latch or enable change one edge after that change, so it lags a new status input by two edges. The bench drives all stimulus at falling edges and queues the expected value of each read as it issues the strobe. A monitor pops that value at the falling edge after the sampling edge, and `irq` is checked only after the extra edge has passed.

// File: rtl/sagg_pkg.sv
package sagg_pkg;
  localparam int BYTE_W  = 8;
  localparam int NUM_SUB = 4;

  localparam int POS_SPARE = 0;
  localparam int POS_CSAT  = 1;
  localparam int POS_SUB0  = 2;
  localparam int POS_TXCL  = 6;
  localparam int POS_RXCL  = 7;

  typedef enum logic [1:0] {
    OFS_LIVE   = 2'd0,
    OFS_LATCH  = 2'd1,
    OFS_ENABLE = 2'd2,
    OFS_SPARE  = 2'd3
  } host_ofs_e;

  typedef logic [BYTE_W-1:0] mbyte_t;
endpackage

// File: rtl/sagg_rst_sync.sv
module sagg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/sagg_sub_summary.sv
module sagg_sub_summary #(
  parameter int SUB_W   = 8,
  parameter int NUM_SUB = 4
) (
  input  logic [NUM_SUB-1:0][SUB_W-1:0] stat,
  input  logic [NUM_SUB-1:0][SUB_W-1:0] en,
  output logic [NUM_SUB-1:0]            hit
);
  for (genvar s = 0; s < NUM_SUB; s++) begin : g_sub
    logic [SUB_W-1:0] masked;
    always_comb begin
      masked = stat[s] & en[s];
      hit[s] = |masked;
    end
  end
endmodule

// File: rtl/sagg_latch_bank.sv
module sagg_latch_bank
  import sagg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  mbyte_t live,
  input  logic   clr_en,
  input  mbyte_t clr_mask,
  output mbyte_t lat
);
  mbyte_t live_q, lat_q;
  mbyte_t rise, lat_d;
  mbyte_t clr_vec;

  always_comb begin
    rise    = live & ~live_q;
    clr_vec = clr_en ? clr_mask : '0;
    // a rising live bit wins over a clearing write in the same cycle
    lat_d   = (lat_q & ~clr_vec) | rise;
    lat_d[POS_SPARE] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      lat_q  <= '0;
    end else begin
      live_q <= live;
      lat_q  <= lat_d;
    end
  end

  assign lat = lat_q;

  assert_rise_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(live & ~live_q)) |=> ((lat_q & $past(live & ~live_q)) == $past(live & ~live_q)));

  assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && ((live & ~live_q) == '0)) |=> ((lat_q & $past(clr_mask)) == '0));

  assert_spare_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_q[POS_SPARE]);
endmodule

// File: rtl/sagg_host_regs.sv
module sagg_host_regs
  import sagg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] host_addr,
  input  logic       host_wr,
  input  logic       host_rd,
  input  mbyte_t     host_wdata,
  input  mbyte_t     live,
  input  mbyte_t     lat,
  output mbyte_t     ien,
  output logic       clr_en,
  output mbyte_t     clr_mask,
  output mbyte_t     host_rdata
);
  host_ofs_e ofs;
  mbyte_t    ien_q, ien_d;
  logic      ien_we;
  mbyte_t    rdata_q, rdata_d;
  logic      rdata_we;

  always_comb begin
    ofs      = host_ofs_e'(host_addr);
    ien_we   = host_wr && (ofs == OFS_ENABLE);
    ien_d    = host_wdata;
    ien_d[POS_SPARE] = 1'b0;
    clr_en   = host_wr && (ofs == OFS_LATCH);
    clr_mask = host_wdata;
    rdata_we = host_rd;
    unique case (ofs)
      OFS_LIVE:   rdata_d = live;
      OFS_LATCH:  rdata_d = lat;
      OFS_ENABLE: rdata_d = ien_q;
      default:    rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (ien_we)   ien_q   <= ien_d;
      if (rdata_we) rdata_q <= rdata_d;
    end
  end

  assign ien        = ien_q;
  assign host_rdata = rdata_q;

  assert_rdata_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> $stable(rdata_q));

  assert_enable_spare_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ien_we |=> !ien_q[POS_SPARE]);
endmodule

// File: rtl/sagg_irq_gen.sv
module sagg_irq_gen
  import sagg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  mbyte_t lat,
  input  mbyte_t ien,
  output logic   irq
);
  mbyte_t pend;
  logic   irq_d, irq_q;

  always_comb begin
    pend  = lat & ien;
    irq_d = |pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;

  assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |=> !irq_q);

  assert_irq_raised_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((lat & ien) != '0) |=> irq_q);
endmodule

// File: rtl/status_aggregator.sv
module status_aggregator
  import sagg_pkg::*;
#(
  parameter int SUB_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SUB_W-1:0] tst_stat,
  input  logic [SUB_W-1:0] tst_en,
  input  logic [SUB_W-1:0] hdlc_stat,
  input  logic [SUB_W-1:0] hdlc_en,
  input  logic [SUB_W-1:0] alm_stat,
  input  logic [SUB_W-1:0] alm_en,
  input  logic [SUB_W-1:0] frm_stat,
  input  logic [SUB_W-1:0] frm_en,
  input  logic             cnt_sat,
  input  logic             tx_clk_lost,
  input  logic             rx_clk_lost,
  input  logic [1:0]       host_addr,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata,
  output logic             irq
);
  logic rst_n_s;
  logic [NUM_SUB-1:0][SUB_W-1:0] stat_arr, en_arr;
  logic [NUM_SUB-1:0]            sub_hit;
  mbyte_t live, lat, ien, clr_mask;
  logic   clr_en;

  sagg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  // subsystem order sets the master bit order from POS_SUB0 upwards
  assign stat_arr = {frm_stat, alm_stat, hdlc_stat, tst_stat};
  assign en_arr   = {frm_en,   alm_en,   hdlc_en,   tst_en};

  sagg_sub_summary #(.SUB_W(SUB_W), .NUM_SUB(NUM_SUB)) u_sum (
    .stat(stat_arr), .en(en_arr), .hit(sub_hit)
  );

  always_comb begin
    live = '0;
    live[POS_CSAT] = cnt_sat;
    live[POS_SUB0 +: NUM_SUB] = sub_hit;
    live[POS_TXCL] = tx_clk_lost;
    live[POS_RXCL] = rx_clk_lost;
  end

  sagg_latch_bank u_lat (
    .clk(clk), .rst_n(rst_n_s), .live(live),
    .clr_en(clr_en), .clr_mask(clr_mask), .lat(lat)
  );

  sagg_host_regs u_regs (
    .clk(clk), .rst_n(rst_n_s), .host_addr(host_addr),
    .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
    .live(live), .lat(lat), .ien(ien), .clr_en(clr_en),
    .clr_mask(clr_mask), .host_rdata(host_rdata)
  );

  sagg_irq_gen u_irq (
    .clk(clk), .rst_n(rst_n_s), .lat(lat), .ien(ien), .irq(irq)
  );

  assert_sub_clear_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (tst_en == '0) |-> !host_rdata[POS_SUB0] || !$past(host_rd) ||
                      ($past(host_addr) != 2'd0) || !$past(tst_en == '0));
endmodule

// File: tb/status_aggregator_tb_top.sv
module status_aggregator_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] tst_stat, tst_en, hdlc_stat, hdlc_en, alm_stat, alm_en, frm_stat, frm_en;
  logic       cnt_sat, tx_clk_lost, rx_clk_lost;
  logic [1:0] host_addr;
  logic       host_wr, host_rd;
  logic [7:0] host_wdata, host_rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { logic [7:0] exp; string tag; } sb_item_t;
  sb_item_t sb_q[$];

  always #5 clk = ~clk;

  status_aggregator #(.SUB_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .tst_stat(tst_stat), .tst_en(tst_en), .hdlc_stat(hdlc_stat), .hdlc_en(hdlc_en),
    .alm_stat(alm_stat), .alm_en(alm_en), .frm_stat(frm_stat), .frm_en(frm_en),
    .cnt_sat(cnt_sat), .tx_clk_lost(tx_clk_lost), .rx_clk_lost(rx_clk_lost),
    .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq)
  );

  // monitor: pops one expected item per read strobe seen at a rising edge
  initial begin
    forever begin
      @(posedge clk);
      if (host_rd) begin
        @(negedge clk);
        if (sb_q.size() == 0) begin
          errors++;
          $display("FAIL scoreboard: read without expected item");
        end else begin
          sb_item_t it;
          it = sb_q.pop_front();
          checks++;
          if (host_rdata !== it.exp) begin
            errors++;
            $display("FAIL %s: rdata actual %h expected %h", it.tag, host_rdata, it.exp);
          end
        end
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
    sb_item_t it;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: irq actual %b expected %b", tag, irq, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    {tst_stat, tst_en, hdlc_stat, hdlc_en, alm_stat, alm_en, frm_stat, frm_en} = '0;
    {cnt_sat, tx_clk_lost, rx_clk_lost} = '0;
    host_addr = '0; host_wr = 0; host_rd = 0; host_wdata = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();

    chk_irq(1'b0, "R1 reset");
    rd(2'd0, 8'h00, "R1 live");
    rd(2'd1, 8'h00, "R1 latched");
    rd(2'd2, 8'h00, "R1 enable");

    // tester subsystem, masked then enabled
    tst_stat = 8'h01; tick();
    rd(2'd0, 8'h00, "R2 masked");
    tst_en = 8'h01;
    rd(2'd0, 8'h04, "R2 tester");
    rd(2'd1, 8'h04, "R5 latched");
    chk_irq(1'b0, "R7 no enable");

    wr(2'd2, 8'h04); tick();
    chk_irq(1'b1, "R7 raised");
    rd(2'd2, 8'h04, "R9 enable readback");

    tst_en = 8'h00;
    rd(2'd0, 8'h00, "R2 enable cleared");
    chk_irq(1'b1, "R7 latch holds irq");
    rd(2'd1, 8'h04, "R5 holds after fall");
    wr(2'd1, 8'h04); tick();
    chk_irq(1'b0, "R7 after clear");
    rd(2'd1, 8'h00, "R6 cleared");

    // other subsystems
    hdlc_en = 8'hF0; hdlc_stat = 8'h10;
    alm_en = 8'h02; alm_stat = 8'h02;
    frm_en = 8'h80; frm_stat = 8'h01;
    rd(2'd0, 8'h18, "R2 hdlc alarm");
    frm_stat = 8'h81;
    rd(2'd0, 8'h38, "R2 framer");
    hdlc_stat = 8'h00;
    rd(2'd0, 8'h30, "R2 status cleared");
    rd(2'd1, 8'h38, "R5 multi");

    // single-bit sources
    cnt_sat = 1; tx_clk_lost = 1; rx_clk_lost = 1;
    rd(2'd0, 8'hF2, "R3 flags");
    cnt_sat = 0;
    rd(2'd0, 8'hF0, "R3 counter clear");
    rd(2'd1, 8'hFA, "R5 flags latched");

    wr(2'd1, 8'h00);
    rd(2'd1, 8'hFA, "R6 zero write");
    wr(2'd1, 8'hFF);
    rd(2'd1, 8'h00, "R6 no relatch");
    tick();
    rd(2'd1, 8'h00, "R6 still clear");

    // rise and clear in one cycle
    cnt_sat = 1;
    wr(2'd1, 8'h02);
    rd(2'd1, 8'h02, "R8 set wins");

    wr(2'd2, 8'hFF);
    rd(2'd2, 8'hFE, "R9 spare bit");
    chk_irq(1'b1, "R7 full enable");
    wr(2'd0, 8'h00);
    rd(2'd2, 8'hFE, "R9 offset0 write");
    wr(2'd3, 8'h00);
    rd(2'd3, 8'h00, "R9 offset3");
    rd(2'd0, 8'hF2, "R4 live read");
    tx_clk_lost = 0; tick(); tick();
    checks++;
    if (host_rdata !== 8'hF2) begin
      errors++;
      $display("FAIL R4 hold: rdata actual %h expected %h", host_rdata, 8'hF2);
    end

    wr(2'd2, 8'h00); tick();
    chk_irq(1'b0, "R7 enable cleared");

    repeat (3) tick();
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule